// File: doc/BRIEF.md
# Dual-Mode 8-bit PWM Timer

This block is an 8-bit timer/counter that compares its count against a programmable threshold and drives a single PWM pin. Software chooses one of two waveforms with one control bit. In the symmetric mode the counter climbs to its top value and falls back to zero, which gives a phase-correct PWM. In the fast mode the counter climbs and wraps from the top to zero, which gives a PWM at twice the symmetric rate.

The counter only advances on cycles where an external prescaler raises the tick enable. A small register port lets software read and write four locations: the counter, the threshold, the control word and the compare flag. Threshold writes go into a shadow register. The new value reaches the comparator only at a period boundary, so the pin never glitches. A compare match sets a sticky flag that software clears by writing a 1 to it.

Top module: `pwm_timer8`

## Requirements
- R1: After reset the counter, the threshold, the control word and the flag all read 0, the counting direction is up, and the PWM pin is low.
- R2: Register select (reg_addr): 0 is the counter, 1 is the threshold (a read returns the shadow value), 2 is the control word, 3 is the flag. In the control word, bit 0 = 1 selects fast (wrap) mode and bits 2:1 are the output action field. In the flag location bit 0 is the flag. The counter, threshold and control locations read back what was last written to them.
- R3: In fast mode each tick adds one to the counter, and the counter goes from 0xFF to 0x00.
- R4: In symmetric mode the counter turns at 0xFF (next value 0xFE) and at 0x00 (next value 0x01).
- R5: On a cycle with tick_en low and no counter write, the counter and the pin keep their values.
- R6: A counter write takes effect on the cycle of the write and overrides any tick in that cycle. Counting resumes on the next tick after the write.
- R7: A compare event occurs only when a tick steps the counter onto the active threshold. A software write that makes the two equal causes no event.
- R8: The flag is set one cycle after the counter shows the threshold value it stepped onto. It stays set until it is cleared.
- R9: Writing 1 to bit 0 of location 3 clears the flag, except that a compare event in the same cycle keeps it set.
- R10: With action field 00 or 01 the pin is low at once and stays low.
- R11: In fast mode, action 10 sets the pin on overflow and clears it on a compare event. Action 11 does the opposite. The pin changes one cycle after the counter shows 0x00 or the threshold.
- R12: In symmetric mode, action 10 clears the pin on an event reached while counting up and sets it on an event reached while counting down. Action 11 does the opposite.
- R13: A threshold write updates only the shadow. The shadow is copied into the active threshold when the counter steps onto 0xFF in symmetric mode, or onto 0x00 in fast mode.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| tick_en | input | 1 | Timer tick from the external prescaler |
| reg_we | input | 1 | Register write strobe |
| reg_addr | input | 2 | Register select for reads and writes |
| reg_wdata | input | 8 | Write data |
| reg_rdata | output | 8 | Read data for reg_addr (combinational) |
| pwm_out | output | 1 | PWM output pin |
| cmp_irq | output | 1 | Sticky compare-match flag |

## Verification
The hardest case to reach from the ports is a flag clear that lands on the same edge as a new compare event. A bare counter write cannot set this up, because a write suppresses the event. The bench therefore writes the counter two steps below the threshold and lets ticks carry it onto the value. It then issues the clear in exactly the cycle where the counter shows the threshold. The down-counting half of the symmetric mode needs similar care. The bench writes the counter near the top so that the direction flips, then waits a computed number of ticks for the falling count to cross the threshold.

// File: rtl/pwm_timer_pkg.sv
// Package: shared register selects and field widths for the PWM timer.
// Assumes the register port uses a 2-bit select.
package pwm_timer_pkg;

    // Register select codes seen on reg_addr
    typedef enum logic [1:0] {
        SEL_COUNT = 2'd0,
        SEL_THRESH = 2'd1,
        SEL_CTRL = 2'd2,
        SEL_FLAG = 2'd3
    } reg_sel_e;

    // Width of the control word and positions of its fields
    localparam int CTRL_W = 3;
    localparam int CTRL_WRAP_BIT = 0;
    localparam int CTRL_ACT_LSB = 1;

endpackage

// File: rtl/pwm_step_counter.sv
// Module: pwm_step_counter
// Holds the count and the direction. In wrap mode it counts up and rolls
// over; in symmetric mode it reverses at the top and at zero. It also
// records whether the last cycle was a tick step, and in which direction,
// so that compare logic can tell a counted arrival from a software write.
// Assumes: load has priority over tick; synchronous active-low reset.
module pwm_step_counter #(
    parameter int CW = 8
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          tick,
    input  logic          wrap_mode,
    input  logic          load,
    input  logic [CW-1:0] load_val,
    output logic [CW-1:0] count,
    output logic          stepped,
    output logic          stepped_up
);
    localparam logic [CW-1:0] TOP = {CW{1'b1}};
    localparam logic [CW-1:0] ONE = {{(CW-1){1'b0}}, 1'b1};

    logic going_up;

    // Count update, direction flip and step bookkeeping
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            count      <= '0;
            going_up   <= 1'b1;
            stepped    <= 1'b0;
            stepped_up <= 1'b1;
        end else if (load) begin
            count   <= load_val;
            stepped <= 1'b0;
        end else if (tick) begin
            stepped <= 1'b1;
            if (wrap_mode) begin
                count      <= count + ONE;
                going_up   <= 1'b1;
                stepped_up <= 1'b1;
            end else if (going_up) begin
                if (count == TOP) begin
                    count      <= TOP - ONE;
                    going_up   <= 1'b0;
                    stepped_up <= 1'b0;
                end else begin
                    count      <= count + ONE;
                    stepped_up <= 1'b1;
                end
            end else begin
                if (count == '0) begin
                    count      <= ONE;
                    going_up   <= 1'b1;
                    stepped_up <= 1'b1;
                end else begin
                    count      <= count - ONE;
                    stepped_up <= 1'b0;
                end
            end
        end else begin
            stepped <= 1'b0;
        end
    end
endmodule

// File: rtl/pwm_thresh_unit.sv
// Module: pwm_thresh_unit
// Keeps the software-visible shadow threshold and the active threshold.
// It flags a compare event when a counted step lands on the active value,
// and an overflow when a wrap-mode step lands on zero. The shadow is copied
// into the active register at the period boundary.
// Assumes: 'stepped' is high only in the cycle after a tick step.
module pwm_thresh_unit #(
    parameter int CW = 8
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          shadow_wr,
    input  logic [CW-1:0] shadow_val,
    input  logic [CW-1:0] count,
    input  logic          stepped,
    input  logic          wrap_mode,
    output logic [CW-1:0] shadow_q,
    output logic          cmp_evt,
    output logic          ovf_evt
);
    localparam logic [CW-1:0] TOP = {CW{1'b1}};

    logic [CW-1:0] active_q;
    logic          boundary;

    // Event decode from the freshly stepped count
    always_comb begin
        cmp_evt  = stepped && (count == active_q);
        ovf_evt  = stepped && wrap_mode && (count == '0);
        boundary = stepped && (wrap_mode ? (count == '0) : (count == TOP));
    end

    // Shadow write and boundary copy into the active threshold
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            shadow_q <= '0;
            active_q <= '0;
        end else begin
            if (boundary) active_q <= shadow_q;
            if (shadow_wr) shadow_q <= shadow_val;
        end
    end
endmodule

// File: rtl/pwm_pin_unit.sv
// Module: pwm_pin_unit
// Drives the PWM pin from compare and overflow events according to the
// 2-bit action field. The field's upper bit connects the pin; the lower
// bit inverts the sense. A compare event takes priority over an overflow.
// Assumes: events are single-cycle pulses.
module pwm_pin_unit (
    input  logic       clk,
    input  logic       rst_n,
    input  logic [1:0] action,
    input  logic       cmp_evt,
    input  logic       ovf_evt,
    input  logic       stepped_up,
    output logic       pin
);
    logic pin_q;

    // Pin state update on events; cleared while disconnected
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            pin_q <= 1'b0;
        end else if (!action[1]) begin
            pin_q <= 1'b0;
        end else if (cmp_evt) begin
            pin_q <= stepped_up ? action[0] : ~action[0];
        end else if (ovf_evt) begin
            pin_q <= ~action[0];
        end
    end

    // Disconnect gating so the pin drops in the cycle the field changes
    always_comb pin = pin_q & action[1];
endmodule

// File: rtl/pwm_flag_unit.sv
// Module: pwm_flag_unit
// Sticky compare flag. A set caused by an event wins over a software clear
// in the same cycle.
// Assumes: clr is a one-cycle write strobe.
module pwm_flag_unit (
    input  logic clk,
    input  logic rst_n,
    input  logic set_evt,
    input  logic clr,
    output logic flag
);
    // Flag hold, clear and set with set priority
    always_ff @(posedge clk) begin
        if (!rst_n) flag <= 1'b0;
        else        flag <= (flag & ~clr) | set_evt;
    end
endmodule

// File: rtl/pwm_timer8.sv
// Module: pwm_timer8 (top)
// Dual-mode PWM timer: symmetric (up/down) or wrap counting, a buffered
// threshold, a configurable pin action and a sticky compare flag, with a
// small register port. Reads are combinational from reg_addr.
// Assumes: tick_en comes from an external prescaler in the clk domain.
module pwm_timer8 #(
    parameter int CW = 8
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          tick_en,
    input  logic          reg_we,
    input  logic [1:0]    reg_addr,
    input  logic [CW-1:0] reg_wdata,
    output logic [CW-1:0] reg_rdata,
    output logic          pwm_out,
    output logic          cmp_irq
);
    import pwm_timer_pkg::*;

    localparam int PAD_W = CW - CTRL_W;

    reg_sel_e              sel;
    logic                  wr_count;
    logic                  wr_thresh;
    logic                  wr_ctrl;
    logic                  flag_clr;
    logic [CTRL_W-1:0]     ctrl_q;
    logic                  mode_wrap;
    logic [1:0]            act_field;
    logic [CW-1:0]         cnt_q;
    logic                  stepped;
    logic                  stepped_up;
    logic [CW-1:0]         shadow_q;
    logic                  cmp_evt;
    logic                  ovf_evt;

    // Register write decode
    always_comb begin
        sel       = reg_sel_e'(reg_addr);
        wr_count  = reg_we && (sel == SEL_COUNT);
        wr_thresh = reg_we && (sel == SEL_THRESH);
        wr_ctrl   = reg_we && (sel == SEL_CTRL);
        flag_clr  = reg_we && (sel == SEL_FLAG) && reg_wdata[0];
        mode_wrap = ctrl_q[CTRL_WRAP_BIT];
        act_field = ctrl_q[CTRL_ACT_LSB +: 2];
    end

    // Control word storage
    always_ff @(posedge clk) begin
        if (!rst_n)       ctrl_q <= '0;
        else if (wr_ctrl) ctrl_q <= reg_wdata[CTRL_W-1:0];
    end

    pwm_step_counter #(.CW(CW)) u_cnt (
        .clk        (clk),
        .rst_n      (rst_n),
        .tick       (tick_en),
        .wrap_mode  (mode_wrap),
        .load       (wr_count),
        .load_val   (reg_wdata),
        .count      (cnt_q),
        .stepped    (stepped),
        .stepped_up (stepped_up)
    );

    pwm_thresh_unit #(.CW(CW)) u_thr (
        .clk        (clk),
        .rst_n      (rst_n),
        .shadow_wr  (wr_thresh),
        .shadow_val (reg_wdata),
        .count      (cnt_q),
        .stepped    (stepped),
        .wrap_mode  (mode_wrap),
        .shadow_q   (shadow_q),
        .cmp_evt    (cmp_evt),
        .ovf_evt    (ovf_evt)
    );

    pwm_pin_unit u_pin (
        .clk        (clk),
        .rst_n      (rst_n),
        .action     (act_field),
        .cmp_evt    (cmp_evt),
        .ovf_evt    (ovf_evt),
        .stepped_up (stepped_up),
        .pin        (pwm_out)
    );

    pwm_flag_unit u_flag (
        .clk     (clk),
        .rst_n   (rst_n),
        .set_evt (cmp_evt),
        .clr     (flag_clr),
        .flag    (cmp_irq)
    );

    // Read-back multiplexer
    always_comb begin
        unique case (sel)
            SEL_COUNT:  reg_rdata = cnt_q;
            SEL_THRESH: reg_rdata = shadow_q;
            SEL_CTRL:   reg_rdata = {{PAD_W{1'b0}}, ctrl_q};
            default:    reg_rdata = {{(CW-1){1'b0}}, cmp_irq};
        endcase
    end
endmodule

// File: rtl/pwm_timer8_chk.sv
// Module: pwm_timer8_chk
// Property checker bound to pwm_timer8. It watches the count, the mode and
// the flag against the register strobes and the tick.
module pwm_timer8_chk #(
    parameter int CW = 8
) (
    input logic          clk,
    input logic          rst_n,
    input logic          tick_en,
    input logic          cnt_wr,
    input logic          flag_clr,
    input logic          wrap,
    input logic [CW-1:0] cnt,
    input logic          irq
);
    localparam logic [CW-1:0] TOP = {CW{1'b1}};
    localparam logic [CW-1:0] ONE = {{(CW-1){1'b0}}, 1'b1};

    p_wrap_step_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (wrap && tick_en && !cnt_wr) |=> (cnt == $past(cnt) + ONE));

    p_turn_top_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (!wrap && tick_en && !cnt_wr && cnt == TOP) |=> (cnt == TOP - ONE));

    p_turn_bottom_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (!wrap && tick_en && !cnt_wr && cnt == '0) |=> (cnt == ONE));

    p_hold_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (!tick_en && !cnt_wr) |=> $stable(cnt));

    p_write_no_event_r7: assert property (@(posedge clk) disable iff (!rst_n)
        cnt_wr |-> ##2 !$rose(irq));

    p_flag_sticky_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (irq && !flag_clr) |=> irq);
endmodule

bind pwm_timer8 pwm_timer8_chk #(.CW(CW)) u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .tick_en  (tick_en),
    .cnt_wr   (wr_count),
    .flag_clr (flag_clr),
    .wrap     (mode_wrap),
    .cnt      (cnt_q),
    .irq      (cmp_irq)
);

// File: tb/pwm_timer8_tb.sv
// Directed bench for pwm_timer8: one task per scenario.
module pwm_timer8_tb;
    localparam logic [1:0] A_CNT  = 2'd0;
    localparam logic [1:0] A_THR  = 2'd1;
    localparam logic [1:0] A_CTRL = 2'd2;
    localparam logic [1:0] A_FLAG = 2'd3;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       tick_en = 1'b0;
    logic       reg_we = 1'b0;
    logic [1:0] reg_addr = 2'd0;
    logic [7:0] reg_wdata = 8'd0;
    logic [7:0] reg_rdata;
    logic       pwm_out;
    logic       cmp_irq;

    int n_chk = 0;
    int n_err = 0;
    bit done = 1'b0;

    pwm_timer8 u_dut (
        .clk       (clk),
        .rst_n     (rst_n),
        .tick_en   (tick_en),
        .reg_we    (reg_we),
        .reg_addr  (reg_addr),
        .reg_wdata (reg_wdata),
        .reg_rdata (reg_rdata),
        .pwm_out   (pwm_out),
        .cmp_irq   (cmp_irq)
    );

    always #4 clk = ~clk;

    task automatic check(input string req, input logic [7:0] act, input logic [7:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_err++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic step(input int n);
        repeat (n) @(posedge clk);
        @(negedge clk);
    endtask

    task automatic reg_wr(input logic [1:0] a, input logic [7:0] d);
        reg_we = 1'b1; reg_addr = a; reg_wdata = d;
        @(posedge clk);
        @(negedge clk);
        reg_we = 1'b0;
    endtask

    task automatic rd(input logic [1:0] a, output logic [7:0] d);
        reg_addr = a;
        #1;
        d = reg_rdata;
    endtask

    task automatic t_reset;
        logic [7:0] v;
        rd(A_CNT, v);  check("R1 count", v, 8'h00);
        rd(A_THR, v);  check("R1 threshold", v, 8'h00);
        rd(A_CTRL, v); check("R1 control", v, 8'h00);
        rd(A_FLAG, v); check("R1 flag", v, 8'h00);
        check("R1 pin", {7'd0, pwm_out}, 8'h00);
    endtask

    task automatic t_regs_hold;
        logic [7:0] v;
        reg_wr(A_THR, 8'h5A);
        reg_wr(A_CTRL, 8'h05);
        reg_wr(A_CNT, 8'h33);
        rd(A_THR, v);  check("R2 threshold readback", v, 8'h5A);
        rd(A_CTRL, v); check("R2 control readback", v, 8'h05);
        rd(A_CNT, v);  check("R2 count readback", v, 8'h33);
        step(5);
        rd(A_CNT, v);  check("R5 count holds without tick", v, 8'h33);
        check("R5 pin holds without tick", {7'd0, pwm_out}, 8'h00);
    endtask

    task automatic t_wrap_count;
        logic [7:0] v;
        tick_en = 1'b1;
        reg_wr(A_CTRL, 8'h01);
        reg_wr(A_CNT, 8'hFE);
        rd(A_CNT, v); check("R6 write overrides tick", v, 8'hFE);
        step(1); rd(A_CNT, v); check("R6 resumes next tick", v, 8'hFF);
        step(1); rd(A_CNT, v); check("R3 wrap to zero", v, 8'h00);
        step(1); rd(A_CNT, v); check("R3 count after wrap", v, 8'h01);
    endtask

    task automatic t_phase_count;
        logic [7:0] v;
        reg_wr(A_CTRL, 8'h00);
        reg_wr(A_CNT, 8'hFE);
        step(1); rd(A_CNT, v); check("R4 reach top", v, 8'hFF);
        step(1); rd(A_CNT, v); check("R4 turn at top", v, 8'hFE);
        step(1); rd(A_CNT, v); check("R4 counting down", v, 8'hFD);
        reg_wr(A_CNT, 8'h01);
        step(1); rd(A_CNT, v); check("R4 reach zero", v, 8'h00);
        step(1); rd(A_CNT, v); check("R4 turn at zero", v, 8'h01);
        step(1); rd(A_CNT, v); check("R4 counting up", v, 8'h02);
        reg_wr(A_FLAG, 8'h01);
        rd(A_FLAG, v); check("R9 plain clear", v, 8'h00);
    endtask

    task automatic t_match_rules;
        reg_wr(A_CNT, 8'h5A);
        check("R7 no flag on equal write", {7'd0, cmp_irq}, 8'h00);
        step(2);
        check("R7 still no flag after write", {7'd0, cmp_irq}, 8'h00);
        reg_wr(A_CNT, 8'h58);
        step(2);
        check("R8 flag not yet at event cycle", {7'd0, cmp_irq}, 8'h00);
        step(1);
        check("R8 flag one cycle after event", {7'd0, cmp_irq}, 8'h01);
        step(3);
        check("R8 flag sticky", {7'd0, cmp_irq}, 8'h01);
        reg_wr(A_CNT, 8'h58);
        step(2);
        reg_wr(A_FLAG, 8'h01);
        check("R9 event beats clear", {7'd0, cmp_irq}, 8'h01);
        reg_wr(A_FLAG, 8'h01);
        check("R9 clear without event", {7'd0, cmp_irq}, 8'h00);
    endtask

    task automatic t_phase_pin;
        logic [7:0] v;
        reg_wr(A_CTRL, 8'h04);
        reg_wr(A_CNT, 8'hFE);
        step(166);
        rd(A_CNT, v); check("R12 down count at threshold", v, 8'h5A);
        check("R12 pin low before down event", {7'd0, pwm_out}, 8'h00);
        step(1);
        check("R12 set on down event", {7'd0, pwm_out}, 8'h01);
        reg_wr(A_CNT, 8'h01);
        step(91);
        rd(A_CNT, v); check("R12 up count at threshold", v, 8'h5A);
        check("R12 pin high before up event", {7'd0, pwm_out}, 8'h01);
        step(1);
        check("R12 clear on up event", {7'd0, pwm_out}, 8'h00);
    endtask

    task automatic t_wrap_pin;
        logic [7:0] v;
        reg_wr(A_THR, 8'h20);
        reg_wr(A_CTRL, 8'h05);
        reg_wr(A_CNT, 8'hFE);
        step(3);
        check("R11 set on overflow", {7'd0, pwm_out}, 8'h01);
        reg_wr(A_THR, 8'h90);
        rd(A_THR, v); check("R13 shadow readback", v, 8'h90);
        step(30);
        rd(A_CNT, v); check("R11 count at threshold", v, 8'h20);
        check("R11 pin high before event", {7'd0, pwm_out}, 8'h01);
        step(1);
        check("R13 old threshold still active", {7'd0, pwm_out}, 8'h00);
        step(112);
        rd(A_CNT, v); check("R13 count past new value", v, 8'h91);
        check("R13 no event on shadow value", {7'd0, pwm_out}, 8'h00);
        step(112);
        check("R11 set on second overflow", {7'd0, pwm_out}, 8'h01);
        reg_wr(A_CTRL, 8'h07);
        step(142);
        rd(A_CNT, v); check("R13 count at loaded value", v, 8'h90);
        step(113);
        rd(A_CNT, v); check("R11 count after overflow", v, 8'h01);
        check("R11 inverted clear on overflow", {7'd0, pwm_out}, 8'h00);
        step(143);
        check("R11 inverted pin before event", {7'd0, pwm_out}, 8'h00);
        step(1);
        check("R11 inverted set on event", {7'd0, pwm_out}, 8'h01);
        reg_wr(A_CTRL, 8'h01);
        check("R10 field 00 forces low", {7'd0, pwm_out}, 8'h00);
        reg_wr(A_CTRL, 8'h03);
        step(300);
        check("R10 field 01 stays low", {7'd0, pwm_out}, 8'h00);
        tick_en = 1'b0;
        rd(A_CNT, v);
        step(4);
        begin
            logic [7:0] w;
            rd(A_CNT, w); check("R5 count frozen", w, v);
        end
    endtask

    initial begin
        #(8 * 200000);
        if (!done) begin
            n_chk++;
            n_err++;
            $display("FAIL watchdog expired");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_err);
            $finish;
        end
    end

    initial begin
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst_n = 1'b1;
        t_reset;
        t_regs_hold;
        t_wrap_count;
        t_phase_count;
        t_match_rules;
        t_phase_pin;
        t_wrap_pin;
        done = 1'b1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_err);
        $finish;
    end
endmodule